// File: doc/BRIEF.md
# Signed Restoring Sequential Divider

This block divides a 2W-bit signed dividend by a W-bit signed divisor, one quotient bit per clock. Both operands arrive in two's complement. They are turned into a sign and a magnitude on entry, and all of the arithmetic works on magnitudes. The quotient sign is the exclusive-or of the two operand signs, and the remainder takes the sign of the dividend. Once the loop ends, each magnitude is negated or left as it is, according to its sign.

A pulse on `start` while the block is idle captures the operands. The next cycle runs a check stage. A zero divisor ends the operation at once. So does a quotient that would not fit in W bits. If the dividend's upper half is zero and its lower half is smaller than the divisor, the answer is known without iterating and the block skips the loop. In every other case the block runs W restoring iterations. Each iteration shifts the partial remainder and the quotient left by one place and subtracts the divisor. When that subtraction goes negative, the old value is kept. `done` pulses once, when the outputs are valid.

Top module: `sm_divider`

## Requirements
- R1: After reset, `busy`, `done`, `ovf` and `div0` are 0, and `quotient` and `remainder` are 0.
- R2: `dividend` is read as a 2W-bit two's complement number and `divisor` as a W-bit two's complement number. The magnitude of the most negative value of each is still handled correctly.
- R3: When the divisor is zero, the operation ends with `div0`=1, `ovf`=0, `quotient`=0 and `remainder`=0. `done` is raised on the 3rd rising edge counted from the edge that accepted `start`.
- R4: When the divisor is nonzero and (|dividend| >> W) >= |divisor|, the operation ends with `ovf`=1, `div0`=0 and both results 0, with the same 3-edge latency.
- R5: When (|dividend| >> W) is 0 and the low W bits of |dividend| are less than |divisor|, the quotient is 0 and the remainder equals the signed dividend. `done` follows after 3 edges and no loop runs.
- R6: In all other cases `quotient` is a (W+1)-bit two's complement value. Its magnitude is floor(|dividend| / |divisor|) and its sign is the XOR of the operand signs.
- R7: In those cases `remainder` is a (W+1)-bit two's complement value. Its magnitude is |dividend| mod |divisor| and its sign is that of the dividend.
- R8: An operation that runs the loop raises `done` on the (W+3)th rising edge counted from the accepting edge, and exactly W iterations take place.
- R9: `busy` is 1 from the accepting edge until the edge that raises `done`. `done` is high for exactly one cycle, and `busy` is 0 in that cycle.
- R10: `start` and the operand inputs are ignored while `busy` is 1. Results, flags and latency stay those of the operation already in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division when idle |
| dividend | input | 2W | Signed dividend |
| divisor | input | W | Signed divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | W+1 | Signed quotient, held until the next completion |
| remainder | output | W+1 | Signed remainder, held until the next completion |
| ovf | output | 1 | Quotient would not fit in W bits |
| div0 | output | 1 | Divisor was zero |

## Verification
The bench sweeps every dividend against every divisor at W=4. This covers the most negative operands, whose magnitudes a careless negation would truncate and turn into wrong quotients. It also covers the exact boundary where the upper half of the dividend equals the divisor: a design that checks overflow with a strict comparison would produce a quotient wrapped into W bits there. The sweep also catches a zero-path remainder returned without the dividend's sign, and a divisor of zero that reports overflow instead of division by zero. It separately catches an off-by-one iteration count, which shows up as a shifted quotient and a wrong latency. A second `start` during a running operation must leave the first result unchanged; a design that re-captured its operands would return the second operation's answer.

// File: rtl/sm_divider.sv
module sm_divider #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [2*W-1:0] dividend,
  input  logic [W-1:0]   divisor,
  output logic           busy,
  output logic           done,
  output logic [W:0]     quotient,
  output logic [W:0]     remainder,
  output logic           ovf,
  output logic           div0
);
  localparam int CW = $clog2(W + 1);

  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_ITER, S_FIN} st_t;

  st_t            st;
  logic [W:0]     acc;
  logic [W-1:0]   qr;
  logic [W-1:0]   bm;
  logic           qsgn, rsgn, e_dz, e_ov;
  logic [CW-1:0]  cnt;

  logic [2*W-1:0] dvd_mag;
  logic [W-1:0]   dvs_mag;
  logic [W:0]     shifted;
  logic [W+1:0]   diff;
  logic           trial_neg;
  logic [W:0]     q_ext;

  assign dvd_mag   = dividend[2*W-1] ? -dividend : dividend;
  assign dvs_mag   = divisor[W-1] ? -divisor : divisor;
  assign shifted   = {acc[W-1:0], qr[W-1]};
  assign diff      = {1'b0, shifted} - {2'b00, bm};
  assign trial_neg = diff[W+1];
  assign q_ext     = {1'b0, qr};
  assign busy      = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      acc       <= '0;
      qr        <= '0;
      bm        <= '0;
      qsgn      <= 1'b0;
      rsgn      <= 1'b0;
      e_dz      <= 1'b0;
      e_ov      <= 1'b0;
      cnt       <= '0;
      done      <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
      ovf       <= 1'b0;
      div0      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            acc  <= {1'b0, dvd_mag[2*W-1:W]};
            qr   <= dvd_mag[W-1:0];
            bm   <= dvs_mag;
            qsgn <= dividend[2*W-1] ^ divisor[W-1];
            rsgn <= dividend[2*W-1];
            e_dz <= 1'b0;
            e_ov <= 1'b0;
            st   <= S_CHECK;
          end
        end
        S_CHECK: begin
          cnt <= '0;
          if (bm == '0) begin
            e_dz <= 1'b1;
            st   <= S_FIN;
          end else if (acc >= {1'b0, bm}) begin
            e_ov <= 1'b1;
            st   <= S_FIN;
          end else if (acc == '0 && qr < bm) begin
            acc <= {1'b0, qr};
            qr  <= '0;
            st  <= S_FIN;
          end else begin
            st <= S_ITER;
          end
        end
        S_ITER: begin
          acc <= trial_neg ? shifted : diff[W:0];
          qr  <= {qr[W-2:0], ~trial_neg};
          cnt <= cnt + 1'b1;
          if (cnt == CW'(W - 1)) st <= S_FIN;
        end
        S_FIN: begin
          done      <= 1'b1;
          ovf       <= e_ov;
          div0      <= e_dz;
          quotient  <= (e_dz || e_ov) ? '0 : (qsgn ? -q_ext : q_ext);
          remainder <= (e_dz || e_ov) ? '0 : (rsgn ? -acc : acc);
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sm_divider_chk.sv
module sm_divider_chk #(
  parameter int W = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic [W:0] quotient,
  input logic [W:0] remainder,
  input logic       ovf,
  input logic       div0
);
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(busy) && !busy));

  assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start && !done) |=> !busy);

  assert_flags_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf && div0));

  assert_err_zero_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (ovf || div0)) |-> (quotient == '0 && remainder == '0));
endmodule

bind sm_divider sm_divider_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .quotient(quotient), .remainder(remainder), .ovf(ovf), .div0(div0)
);

// File: tb/sm_divider_tb.sv
module sm_divider_tb_top;
  localparam int W = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [2*W-1:0] dividend = '0;
  logic [W-1:0]   divisor = '0;
  logic           busy, done, ovf, div0;
  logic [W:0]     quotient, remainder;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  sm_divider #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .quotient(quotient), .remainder(remainder),
    .ovf(ovf), .div0(div0)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_op(input int dv, input int sv, input bit disturb);
    int dmag, smag, hi, lo, qm, rm, eq, er, elat, n;
    bit edz, eov, ezero;
    dmag = (dv < 0) ? -dv : dv;
    smag = (sv < 0) ? -sv : sv;
    hi = dmag >> W;
    lo = dmag % (1 << W);
    edz = (smag == 0);
    eov = !edz && (hi >= smag);
    ezero = !edz && !eov && (hi == 0) && (lo < smag);
    if (edz || eov) begin
      eq = 0; er = 0;
    end else begin
      qm = dmag / smag;
      rm = dmag % smag;
      eq = ((dv < 0) != (sv < 0)) ? -qm : qm;
      er = (dv < 0) ? -rm : rm;
    end
    elat = (edz || eov || ezero) ? 3 : W + 3;

    @(negedge clk);
    dividend = dv[2*W-1:0];
    divisor  = sv[W-1:0];
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    if (disturb) chk("R9 busy after accept", int'(busy), 1);
    while (!done && n < 40) begin
      if (disturb && n == 2) begin
        dividend = 8'sd100;
        divisor  = 4'sd3;
        start    = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    if (edz) begin
      chk("R3 div0", int'(div0), 1);
      chk("R3 ovf", int'(ovf), 0);
      chk("R3 latency", n, elat);
    end else if (eov) begin
      chk("R4 ovf", int'(ovf), 1);
      chk("R4 div0", int'(div0), 0);
      chk("R4 latency", n, elat);
    end else if (ezero) begin
      chk("R5 flags", int'({ovf, div0}), 0);
      chk("R5 latency", n, elat);
    end else begin
      chk("R8 flags", int'({ovf, div0}), 0);
      chk("R8 latency", n, elat);
    end
    chk(disturb ? "R10 quotient" : "R6 quotient", int'($signed(quotient)), eq);
    chk(disturb ? "R10 remainder" : "R7 remainder", int'($signed(remainder)), er);
    chk("R9 busy low with done", int'(busy), 0);
    @(negedge clk);
    chk("R9 done one cycle", int'(done), 0);
  endtask

  initial begin
    #1500000;
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 flags", int'({ovf, div0}), 0);
    chk("R1 quotient", int'(quotient), 0);
    chk("R1 remainder", int'(remainder), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", int'(busy), 0);

    // R2: most negative operands first
    run_op(-(1 << (2*W-1)), -(1 << (W-1)), 1'b0);
    run_op(-(1 << (2*W-1)) + 1, -(1 << (W-1)), 1'b0);
    run_op(-(1 << (2*W-1)), (1 << (W-1)) - 1, 1'b0);

    // R10: start pulsed while busy
    run_op(-77, 5, 1'b1);
    run_op(45, -7, 1'b1);

    for (int dv = -(1 << (2*W-1)); dv < (1 << (2*W-1)); dv++)
      for (int sv = -(1 << (W-1)); sv < (1 << (W-1)); sv++)
        run_op(dv, sv, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule